// File: doc/BRIEF.md
# Programmable Countdown Watchdog Timer

This block is a small watchdog timer for a low-power timekeeping chip. The host loads a 5-bit countdown value with a single-cycle write strobe. While the timer runs, the live count drops by one on each cycle where the slow tick enable is high. When a period ends, a sticky flag is raised and an interrupt is produced. After that the timer either re-arms itself from the stored load value (repeat) or parks at zero (single-shot).

The controller is a two-state machine. `WD_STOPPED` ignores ticks and holds the count at zero. `WD_RUNNING` counts down. The transitions are:

- **T_START**: a non-zero write moves the machine from STOPPED to RUNNING.
- **T_RELOAD**: a write while RUNNING replaces the count at once and stays RUNNING.
- **T_HALT**: a zero write moves the machine from RUNNING to STOPPED.
- **T_REARM**: a period end in repeat mode stays RUNNING and reloads the count.
- **T_ONESHOT_END**: a period end in single-shot mode moves the machine from RUNNING to STOPPED.

A write always wins over a tick in the same cycle. The load value is kept in its own register, so the live count can be observed at any time while repeat mode still has the value it needs for the next period. The interrupt output can be one clock wide per period end, or it can follow the flag.

Top module: `wdog_countdown`

## Requirements
- R1: After reset the live count is 0, the flag and interrupt are low, and the timer is stopped, so ticks leave the count at 0.
- R2: A write of a non-zero value V makes `count_o` equal V on the following cycle and starts the countdown.
- R3: A write of 0 makes `count_o` 0 on the following cycle and stops the timer, so later ticks have no effect.
- R4: A write that arrives mid-period replaces the live count immediately, even when a tick is high in the same cycle.
- R5: While running, each tick without a write lowers the count by exactly one. Without a tick or a write the count holds.
- R6: In repeat mode (`repeat_i`=1), the tick that finds the count at 1 sets the flag and reloads the count with the last non-zero value written.
- R7: In single-shot mode (`repeat_i`=0), the tick that finds the count at 1 sets the flag and leaves the count at 0 and stopped until the next non-zero write.
- R8: The flag is sticky. Only `flag_clr_i` clears it, and a period end in the same cycle as a clear leaves it set.
- R9: In pulsed mode (`irq_pulse_i`=1), `irq_o` is high for exactly the one cycle in which the flag is set by a period end.
- R10: In level mode (`irq_pulse_i`=0), `irq_o` equals the flag.
- R11: A period from load to period end lasts exactly V ticks. In repeat mode every later period also lasts exactly V ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle countdown enable |
| wr_en_i | input | 1 | Host write strobe for the load value |
| wr_data_i | input | 5 | Load value; 0 stops the timer |
| repeat_i | input | 1 | 1 = repeat, 0 = single-shot |
| irq_pulse_i | input | 1 | 1 = pulsed interrupt, 0 = level interrupt |
| flag_clr_i | input | 1 | Host command that clears the flag |
| count_o | output | 5 | Live counter value |
| flag_o | output | 1 | Sticky period-end flag |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench builds the block with the default 5-bit counter width. This makes every legal load value from 1 to 31 reachable. It includes a load of 1, where consecutive ticks produce back-to-back period ends, and the maximum of 31. At this width, random stimulus that mixes writes, ticks, clears and mode changes hits period ends in both modes within a few thousand cycles. It also hits clear-versus-set collisions and zero writes during a running period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic {
        WD_STOPPED = 1'b0,
        WD_RUNNING = 1'b1
    } wd_state_e;
endpackage

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             repeat_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] reload_q;
    logic             wr_start, wr_halt, tick_live, at_end;

    assign wr_start  = wr_en_i && (wr_data_i != CNT_ZERO);
    assign wr_halt   = wr_en_i && (wr_data_i == CNT_ZERO);
    assign tick_live = (state_q == WD_RUNNING) && tick_i && !wr_en_i;
    assign at_end    = tick_live && (count_q == CNT_ONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_STOPPED;
        else        state_q <= state_d;
    end

    // Next state: named transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_STOPPED: begin
                if (wr_start) state_d = WD_RUNNING;              // T_START
            end
            WD_RUNNING: begin
                if (wr_halt)                   state_d = WD_STOPPED; // T_HALT
                else if (wr_start)             state_d = WD_RUNNING; // T_RELOAD
                else if (at_end && !repeat_i)  state_d = WD_STOPPED; // T_ONESHOT_END
                else if (at_end)               state_d = WD_RUNNING; // T_REARM
            end
            default: state_d = WD_STOPPED;
        endcase
    end

    // Counter next value
    always_comb begin
        count_d = count_q;
        if (wr_en_i)                count_d = wr_data_i;
        else if (at_end && repeat_i) count_d = reload_q;
        else if (at_end)             count_d = CNT_ZERO;
        else if (tick_live)          count_d = count_q - CNT_ONE;
    end

    // Count and reload registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= CNT_ZERO;
            reload_q <= CNT_ZERO;
        end else begin
            count_q <= count_d;
            if (wr_en_i) reload_q <= wr_data_i;
        end
    end

    assign count_o  = count_q;
    assign expire_o = at_end;

    // R2, R4: a write lands in the count on the next cycle
    p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (count_o == $past(wr_data_i)));
    // R5: no tick and no write keeps the count
    p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en_i) |=> $stable(count_o));
    // R5: running tick above 1 decrements by one
    p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RUNNING && tick_i && !wr_en_i && count_q > CNT_ONE)
        |=> (count_o == $past(count_o) - CNT_ONE));
    // R3, R7: a stopped timer shows zero
    p_stopped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_STOPPED) |-> (count_q == CNT_ZERO));
    // R6: repeat period end re-arms with a non-zero count
    p_rearm_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && repeat_i) |=> (count_o != CNT_ZERO && state_q == WD_RUNNING));
endmodule

// File: rtl/wdog_irq.sv
module wdog_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic flag_clr_i,
    input  logic irq_pulse_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q, pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= expire_i;
            if (expire_i)        flag_q <= 1'b1;
            else if (flag_clr_i) flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = irq_pulse_i ? pulse_q : flag_q;

    // R8: the flag only falls on a clear command
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr_i) |=> flag_q);
    // R6, R7: the flag only rises after a period end
    p_flag_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(expire_i));
    // R9: a pulse coincides with a set flag
    p_pulse_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> flag_q);
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             repeat_i,
    input  logic             irq_pulse_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             irq_o
);
    logic expire;

    wdog_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .repeat_i  (repeat_i),
        .count_o   (count_o),
        .expire_o  (expire)
    );

    wdog_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire_i    (expire),
        .flag_clr_i  (flag_clr_i),
        .irq_pulse_i (irq_pulse_i),
        .flag_o      (flag_o),
        .irq_o       (irq_o)
    );
endmodule

// File: tb/wdog_countdown_bench.sv
module wdog_countdown_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_i = 1'b0, wr_en_i = 1'b0, flag_clr_i = 1'b0;
    logic [W-1:0] wr_data_i = '0;
    logic         repeat_i = 1'b1, irq_pulse_i = 1'b1;
    logic [W-1:0] count_o;
    logic         flag_o, irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [W-1:0] m_cnt = '0, m_rld = '0;
    bit m_run = 0, m_flag = 0, m_pulse = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_countdown #(.CNT_W(W)) u_wdog_countdown (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .repeat_i(repeat_i), .irq_pulse_i(irq_pulse_i),
        .flag_clr_i(flag_clr_i), .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    function automatic bit exp_irq();
        return irq_pulse_i ? m_pulse : m_flag;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "count", int'(count_o), int'(m_cnt));
        chk(tag, "flag",  int'(flag_o),  int'(m_flag));
        chk(tag, "irq",   int'(irq_o),   int'(exp_irq()));
    endtask

    // one clock: drive at negedge, model the edge, compare at next negedge
    task automatic cyc(input bit t, input bit w, input logic [W-1:0] d,
                       input bit c, input string tag);
        bit evt;
        tick_i = t; wr_en_i = w; wr_data_i = d; flag_clr_i = c;
        @(posedge clk);
        evt = 0;
        if (w) begin
            m_cnt = d; m_rld = d; m_run = (d != 0);
        end else if (m_run && t) begin
            if (m_cnt == 1) begin
                evt = 1;
                if (repeat_i) m_cnt = m_rld;
                else begin m_cnt = 0; m_run = 0; end
            end else m_cnt = m_cnt - 1;
        end
        if (evt) m_flag = 1; else if (c) m_flag = 0;
        m_pulse = evt;
        @(negedge clk);
        tick_i = 0; wr_en_i = 0; flag_clr_i = 0;
        chk_all(tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int periods;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        // R1: ticks after reset do nothing
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, "R1");
        chk("R1", "stopped count", int'(count_o), 0);

        // R2 / R11 / R6 / R9: repeat, pulsed, load 5
        repeat_i = 1; irq_pulse_i = 1;
        cyc(0, 1, 5'd5, 0, "R2");
        chk("R2", "loaded", int'(count_o), 5);
        cyc(0, 0, 0, 0, "R5");
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, "R5");
        chk("R11", "flag not before 5 ticks", int'(flag_o), 0);
        cyc(1, 0, 0, 0, "R6");
        chk("R6", "reload", int'(count_o), 5);
        chk("R9", "pulse", int'(irq_o), 1);
        cyc(0, 0, 0, 0, "R9");
        chk("R9", "pulse ended", int'(irq_o), 0);
        // R11: second period exact
        cyc(0, 0, 0, 1, "R8");
        chk("R8", "cleared", int'(flag_o), 0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, "R11");
        chk("R11", "no early end", int'(flag_o), 0);
        cyc(1, 0, 0, 1, "R8");
        chk("R8", "set wins over clear", int'(flag_o), 1);
        chk("R11", "second period", int'(count_o), 5);

        // R4: mid-period write with simultaneous tick
        cyc(1, 0, 0, 0, "R4");
        cyc(1, 1, 5'd9, 0, "R4");
        chk("R4", "replaced", int'(count_o), 9);

        // R10: level mode follows flag
        irq_pulse_i = 0;
        @(negedge clk);
        chk("R10", "level irq", int'(irq_o), int'(flag_o));
        cyc(0, 0, 0, 1, "R10");
        chk("R10", "level irq low", int'(irq_o), 0);

        // R3: zero write halts
        cyc(0, 1, 5'd0, 0, "R3");
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, "R3");
        chk("R3", "halted", int'(count_o), 0);

        // R7: single-shot load 2
        repeat_i = 0;
        cyc(0, 1, 5'd2, 0, "R7");
        cyc(1, 0, 0, 0, "R7");
        cyc(1, 0, 0, 0, "R7");
        chk("R7", "flag", int'(flag_o), 1);
        chk("R7", "parked", int'(count_o), 0);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, "R7");
        chk("R7", "still parked", int'(count_o), 0);

        // R11: load 1 with every-cycle ticks in repeat, and maximum 31
        repeat_i = 1; irq_pulse_i = 1;
        cyc(0, 1, 5'd1, 1, "R11");
        periods = 0;
        for (int i = 0; i < 4; i++) begin cyc(1, 0, 0, 0, "R11"); periods += int'(irq_o); end
        chk("R11", "load 1 pulses", periods, 4);
        cyc(0, 1, 5'd31, 1, "R11");
        periods = 0;
        for (int i = 0; i < 62; i++) begin cyc(1, 0, 0, 0, "R11"); periods += int'(irq_o); end
        chk("R11", "load 31 pulses", periods, 2);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit t, w, c;
            logic [W-1:0] d;
            if ($urandom_range(0, 199) == 0) repeat_i = ~repeat_i;
            if ($urandom_range(0, 149) == 0) irq_pulse_i = ~irq_pulse_i;
            t = ($urandom_range(0, 2) == 0);
            w = ($urandom_range(0, 39) == 0);
            c = ($urandom_range(0, 29) == 0);
            d = W'($urandom_range(0, 31));
            if (d == 0 && $urandom_range(0, 3) != 0) d = 5'd3;
            cyc(t, w, d, c, "R5");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule